// File: doc/BRIEF.md
# Modem Line Status Register with Transmit Flow Gate

This block watches the four incoming modem handshake lines of a serial port (carrier detect, ring indicator, data-set-ready and clear-to-send) and presents them to the CPU as one 8-bit status byte. The pins are active low. Each one passes through a synchronizer into the register clock domain. The upper nibble of the byte shows the present asserted state of each line. The lower nibble holds sticky change flags that record what has happened since the CPU last read the byte. A modem interrupt stays raised while any flag is set.

A loopback mode disconnects the pins and feeds the status nibble from the port's own modem-control outputs. Change detection runs after this selection, so entering or leaving loopback can itself raise flags.

When hardware flow control is enabled, the block also gives the transmitter a go/stop permission that follows clear-to-send. That permission is only re-evaluated at a character boundary, so a character that has started always finishes.

Top module: `modem_stat_reg`

## Requirements
- R1: While reset is held, and after reset is released, the change nibble `status[3:0]` is 0, `modem_irq` is 0 and `tx_go` is 0 during reset. Filling the synchronizers after reset never raises a change flag.
- R2: Outside loopback, `status[7]`, `status[6]`, `status[5]` and `status[4]` are the inverses of `dcd_n`, `ri_n`, `dsr_n` and `cts_n` respectively. A pin change appears in `status` after exactly two rising clock edges.
- R3: With `loop_en`=1, `status[7:4]` equals {`ctl_aux2`, `ctl_aux1`, `ctl_dtr`, `ctl_rts`} in the same cycle, and the four pins have no effect on `status`.
- R4: When `status[7]`, `status[5]` or `status[4]` changes in either direction, the flag `status[3]`, `status[1]` or `status[0]` respectively is 1 from the next rising edge onward. Outside loopback, this is three edges after the pin change.
- R5: `status[2]` is set only when `status[6]` goes from 1 to 0, which outside loopback is `ri_n` going from 0 to 1. A 0-to-1 change of `status[6]` leaves `status[2]` unchanged.
- R6: Switching `loop_en` sets a change flag for every status line whose selected value differs across the switch.
- R7: A cycle with `rd_stb`=1 shows the current flags on `status`. At the following edge, all four flags are cleared.
- R8: A change that is registered at the same edge as a read leaves its flag set after the read. Without a read, a flag never clears.
- R9: `modem_irq` is 1 exactly when any of `status[3:0]` is 1.
- R10: With `flow_en`=0, `tx_go` is 1 one edge later.
- R11: With `flow_en`=1, `tx_go` loads `status[4]` at an edge where `tx_boundary`=1 and holds its value at every other edge. In loopback this means it follows `ctl_rts`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dcd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| loop_en | input | 1 | Loopback select from the modem control register |
| ctl_aux2 | input | 1 | Second auxiliary control output, loopback source of bit 7 |
| ctl_aux1 | input | 1 | First auxiliary control output, loopback source of bit 6 |
| ctl_dtr | input | 1 | Data-terminal-ready control output, loopback source of bit 5 |
| ctl_rts | input | 1 | Request-to-send control output, loopback source of bit 4 |
| rd_stb | input | 1 | One-cycle CPU read strobe of the status byte |
| flow_en | input | 1 | Hardware flow control enable |
| tx_boundary | input | 1 | Transmitter is between characters this cycle |
| status | output | 8 | Line state in [7:4], change flags in [3:0] |
| modem_irq | output | 1 | Modem status interrupt |
| tx_go | output | 1 | Permission for the transmitter to start a character |

## Verification
The hardest case to reach from the ports is a line change that is registered at exactly the edge where a read clears the flags. Reaching it needs the stimulus to count the full synchronizer and edge-detect latency. The bench therefore moves `dsr_n` and asserts `rd_stb` two edges later, so that the read and the arrival of the flag coincide. It then checks that the read returned the old flags and that the new flag survives. Loopback transitions are driven with pin and control values chosen so that some lines differ across the switch and others do not, including a falling ring line that must flag and a rising one that must not.

// File: rtl/mstat_pkg.sv
`timescale 1ns/1ps
package mstat_pkg;
  // Order is the register layout: carrier, ring, data-set-ready, clear-to-send
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mline_t;

  localparam int LINES = 4;
endpackage

// File: rtl/mstat_sync.sv
`timescale 1ns/1ps
module mstat_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_next
      assign stg_d = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= RST_VAL;
      else        stg_q[g] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/mstat_delta.sv
`timescale 1ns/1ps
module mstat_delta
  import mstat_pkg::*;
#(
  parameter int PRIME_CYC = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  mline_t cur,
  input  logic   rd_stb,
  output mline_t delta,
  output logic   primed
);
  localparam int CW = $clog2(PRIME_CYC + 1);

  mline_t        prev_q;
  mline_t        delta_q, delta_d;
  mline_t        ev;
  logic [CW-1:0] cnt_q, cnt_d;

  assign primed = (cnt_q == CW'(PRIME_CYC));

  // Edge events; ring flags only its trailing (1 -> 0) edge
  always_comb begin
    ev = '0;
    if (primed) begin
      ev.dcd = cur.dcd ^ prev_q.dcd;
      ev.ri  = prev_q.ri & ~cur.ri;
      ev.dsr = cur.dsr ^ prev_q.dsr;
      ev.cts = cur.cts ^ prev_q.cts;
    end
  end

  always_comb begin
    delta_d = (rd_stb ? mline_t'('0) : delta_q) | ev;
    cnt_d   = primed ? cnt_q : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      delta_q <= '0;
      cnt_q   <= '0;
    end else begin
      prev_q  <= cur;
      delta_q <= delta_d;
      cnt_q   <= cnt_d;
    end
  end

  assign delta = delta_q;
endmodule

// File: rtl/mstat_txgate.sv
`timescale 1ns/1ps
module mstat_txgate (
  input  logic clk,
  input  logic rst_n,
  input  logic flow_en,
  input  logic boundary,
  input  logic cts_ok,
  output logic tx_go
);
  logic go_q, go_d;

  always_comb begin
    if (!flow_en)      go_d = 1'b1;
    else if (boundary) go_d = cts_ok;
    else               go_d = go_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) go_q <= 1'b0;
    else        go_q <= go_d;
  end

  assign tx_go = go_q;
endmodule

// File: rtl/modem_stat_reg.sv
`timescale 1ns/1ps
module modem_stat_reg
  import mstat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dcd_n,
  input  logic       ri_n,
  input  logic       dsr_n,
  input  logic       cts_n,
  input  logic       loop_en,
  input  logic       ctl_aux2,
  input  logic       ctl_aux1,
  input  logic       ctl_dtr,
  input  logic       ctl_rts,
  input  logic       rd_stb,
  input  logic       flow_en,
  input  logic       tx_boundary,
  output logic [7:0] status,
  output logic       modem_irq,
  output logic       tx_go
);
  localparam int PRIME_CYC = SYNC_STAGES + 1;

  logic   rst_core_n;
  logic   primed;
  mline_t pin_q;
  mline_t cur;
  mline_t delta;

  // Reset: asserted asynchronously, released through a synchronizer
  mstat_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_core_n)
  );

  mstat_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     ({dcd_n, ri_n, dsr_n, cts_n}),
    .q     (pin_q)
  );

  always_comb begin
    if (loop_en) cur = '{dcd: ctl_aux2, ri: ctl_aux1, dsr: ctl_dtr, cts: ctl_rts};
    else         cur = ~pin_q;
  end

  mstat_delta #(.PRIME_CYC(PRIME_CYC)) u_delta (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .cur    (cur),
    .rd_stb (rd_stb),
    .delta  (delta),
    .primed (primed)
  );

  mstat_txgate u_txgate (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .flow_en  (flow_en),
    .boundary (tx_boundary),
    .cts_ok   (cur.cts),
    .tx_go    (tx_go)
  );

  assign status    = {cur, delta};
  assign modem_irq = |delta;
endmodule

// File: rtl/mstat_checker.sv
`timescale 1ns/1ps
module mstat_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       primed,
  input logic       rd_stb,
  input logic       flow_en,
  input logic       tx_boundary,
  input logic [7:0] status,
  input logic       tx_go
);
  a_r1_quiet_until_primed: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> (status[3:0] == 4'h0));

  a_r4_dcd_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$stable(status[7])) |=> status[3]);

  a_r4_dsr_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$stable(status[5])) |=> status[1]);

  a_r4_cts_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$stable(status[4])) |=> status[0]);

  a_r5_ri_rise_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && $rose(status[6])) |=> !status[2]);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && $stable(status[7:4])) |=> (status[3:0] == 4'h0));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((status[3:0] & $past(status[3:0])) == $past(status[3:0])));

  a_r10_flow_off_go: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_en |=> tx_go);

  a_r11_hold_mid_char: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && !tx_boundary) |=> $stable(tx_go));

  a_r11_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && tx_boundary) |=> (tx_go == $past(status[4])));
endmodule

bind modem_stat_reg mstat_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .primed      (primed),
  .rd_stb      (rd_stb),
  .flow_en     (flow_en),
  .tx_boundary (tx_boundary),
  .status      (status),
  .tx_go       (tx_go)
);

// File: tb/modem_stat_reg_bench.sv
`timescale 1ns/1ps
module modem_stat_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       dcd_n, ri_n, dsr_n, cts_n;
  logic       loop_en, ctl_aux2, ctl_aux1, ctl_dtr, ctl_rts;
  logic       rd_stb, flow_en, tx_boundary;
  logic [7:0] status;
  logic       modem_irq, tx_go;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  modem_stat_reg u_modem_stat_reg (
    .clk(clk), .rst_n(rst_n),
    .dcd_n(dcd_n), .ri_n(ri_n), .dsr_n(dsr_n), .cts_n(cts_n),
    .loop_en(loop_en), .ctl_aux2(ctl_aux2), .ctl_aux1(ctl_aux1),
    .ctl_dtr(ctl_dtr), .ctl_rts(ctl_rts),
    .rd_stb(rd_stb), .flow_en(flow_en), .tx_boundary(tx_boundary),
    .status(status), .modem_irq(modem_irq), .tx_go(tx_go)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_read(input string req, input logic [7:0] pre, input logic [7:0] post);
    rd_stb = 1'b1;
    #1;
    chk(req, status, pre);
    tick(1);
    rd_stb = 1'b0;
    chk(req, status, post);
    chk(req, {7'd0, modem_irq}, {7'd0, post[3:0] != 4'h0});
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    tick(3);
    chk("R1 status in reset", status, 8'h00);
    chk("R1 irq in reset", {7'd0, modem_irq}, 8'h00);
    chk("R1 tx_go in reset", {7'd0, tx_go}, 8'h00);
    rst_n = 1'b1;
    tick(8);
    chk("R1 R2 after reset, no fill flags", status, 8'h10);
    chk("R1 irq after reset", {7'd0, modem_irq}, 8'h00);
    chk("R10 tx_go flow off", {7'd0, tx_go}, 8'h01);
  endtask

  task automatic t_pins;
    cts_n = 1'b1;
    tick(3);
    do_read("R4 cts flag", 8'h01, 8'h00);
    dcd_n = 1'b0;
    tick(1);
    chk("R2 latency one edge", status, 8'h00);
    tick(1);
    chk("R2 latency two edges", status, 8'h80);
    tick(1);
    chk("R4 dcd fall flag", status, 8'h88);
    chk("R9 irq raised", {7'd0, modem_irq}, 8'h01);
    tick(2);
    chk("R8 flag held without read", status, 8'h88);
    do_read("R7 read clears dcd", 8'h88, 8'h80);
    dcd_n = 1'b1;
    tick(3);
    do_read("R4 dcd rise flag", 8'h08, 8'h00);
    dsr_n = 1'b0;
    tick(3);
    do_read("R4 dsr flag", 8'h22, 8'h20);
    dsr_n = 1'b1;
    tick(3);
    do_read("R4 dsr flag back", 8'h02, 8'h00);
  endtask

  task automatic t_ri;
    ri_n = 1'b0;
    tick(3);
    chk("R5 ri assert no flag", status, 8'h40);
    ri_n = 1'b1;
    tick(3);
    chk("R5 ri release flag", status, 8'h04);
    do_read("R5 ri clear", 8'h04, 8'h00);
  endtask

  task automatic t_collide;
    dsr_n = 1'b0;
    tick(2);
    rd_stb = 1'b1;
    #1;
    chk("R7 read shows old flags", status, 8'h20);
    tick(1);
    rd_stb = 1'b0;
    chk("R8 change during read kept", status, 8'h22);
    chk("R8 irq kept", {7'd0, modem_irq}, 8'h01);
    do_read("R8 later read clears", 8'h22, 8'h20);
    dsr_n = 1'b1;
    tick(3);
    do_read("R8 cleanup", 8'h02, 8'h00);
  endtask

  task automatic t_loop;
    loop_en = 1'b1; ctl_aux2 = 1'b1; ctl_aux1 = 1'b0; ctl_dtr = 1'b1; ctl_rts = 1'b0;
    #1;
    chk("R3 loopback map A", status, 8'hA0);
    tick(1);
    chk("R6 enter loopback flags", status, 8'hAA);
    do_read("R6 clear", 8'hAA, 8'hA0);
    ctl_aux2 = 1'b0; ctl_aux1 = 1'b1; ctl_dtr = 1'b0; ctl_rts = 1'b1;
    #1;
    chk("R3 loopback map B", status, 8'h50);
    tick(1);
    chk("R5 R4 loopback changes", status, 8'h5B);
    do_read("R7 loopback clear", 8'h5B, 8'h50);
    cts_n = 1'b0; dcd_n = 1'b0;
    tick(4);
    chk("R3 pins ignored in loopback", status, 8'h50);
    dcd_n = 1'b1;
    tick(4);
    loop_en = 1'b0;
    #1;
    chk("R2 pins selected again", status, 8'h10);
    tick(1);
    chk("R6 R5 leave loopback flags", status, 8'h14);
    do_read("R6 clear after leave", 8'h14, 8'h10);
  endtask

  task automatic t_flow;
    chk("R10 go with flow off", {7'd0, tx_go}, 8'h01);
    flow_en = 1'b1;
    cts_n = 1'b1;
    tick(4);
    chk("R11 held mid character", {7'd0, tx_go}, 8'h01);
    tx_boundary = 1'b1;
    tick(1);
    tx_boundary = 1'b0;
    chk("R11 stop at boundary", {7'd0, tx_go}, 8'h00);
    cts_n = 1'b0;
    tick(4);
    chk("R11 stop held", {7'd0, tx_go}, 8'h00);
    tx_boundary = 1'b1;
    tick(1);
    tx_boundary = 1'b0;
    chk("R11 resume at boundary", {7'd0, tx_go}, 8'h01);
    loop_en = 1'b1; ctl_rts = 1'b0;
    tx_boundary = 1'b1;
    tick(1);
    tx_boundary = 1'b0;
    chk("R11 loopback rts gates", {7'd0, tx_go}, 8'h00);
    loop_en = 1'b0;
    flow_en = 1'b0;
    tick(1);
    chk("R10 flow disabled go", {7'd0, tx_go}, 8'h01);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog R1-timeout: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    dcd_n = 1'b1; ri_n = 1'b1; dsr_n = 1'b1; cts_n = 1'b0;
    loop_en = 1'b0; ctl_aux2 = 1'b0; ctl_aux1 = 1'b0; ctl_dtr = 1'b0; ctl_rts = 1'b0;
    rd_stb = 1'b0; flow_en = 1'b0; tx_boundary = 1'b0;
    @(negedge clk);
    t_reset();
    t_pins();
    t_ri();
    t_collide();
    t_loop();
    t_flow();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule